// File: doc/BRIEF.md
# Byte-Fed CRC-16 Accumulator

This block is a CRC-16 accumulator for checking infrared link frames. Software reaches it through a small word-addressed register port: one address to clear it and read its byte count, one to feed it bytes, and one to read the checksum. Each write to the feed address folds the low byte of the written word into a 16-bit CRC in a single clock cycle. A 12-bit saturating counter records how many bytes have been folded in since the last clear.

The default configuration is the reflected CCITT code. Polynomial constant 0x8408 is applied least significant bit first. The register starts from all ones, and the result is the register inverted. Under these settings the four bytes 0xCC, 0xF5, 0xF1, 0xA7 fed after a clear give 0x51DF. Software can use this sequence as a power-on self-check. Parameters choose the widths, the polynomial, the start and inversion values, and a bit-order variant that shifts most significant bit first.

Top module: `crc_byte_engine`

## Requirements
- R1: After reset the count field reads 0 and the result register reads 0x0000, because the internal state starts at 0xFFFF and the output is inverted.
- R2: A write to the control address (word 0) with bit 15 set returns the CRC state to its start value and the count to 0. A control write with bit 15 clear changes neither.
- R3: Each write to the feed address (word 1) folds bits 7:0 of the written word into the CRC. Processing is least significant bit first with polynomial 0x8408: for each bit, if the state's bit 0 XOR the data bit is 1, the state becomes (state>>1)^0x8408; otherwise it becomes state>>1. Bits 15:8 of the written word have no effect.
- R4: Reading the control address returns the byte count in bits 11:0 and 0 in bits 15:12. Each feed write adds one to the count.
- R5: The count saturates at 0xFFF. Further feed writes leave it at 0xFFF and still update the CRC.
- R6: After a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and a result of 0x51DF.
- R7: Feed writes on consecutive clock cycles are each absorbed, one byte per cycle, with no gap required.
- R8: Writes to the result address (word 2) or to the unused address (word 3) change neither the CRC nor the count.
- R9: The result register (word 2) reads the CRC state XOR 0xFFFF. Read data is combinational from the address, and reflects a write from the clock edge that took it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Word address: 0 control, 1 feed, 2 result, 3 unused |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |

## Verification
A feed or control write is taken at the rising edge where wr_en is high. Both the count and the result are due at that same edge, because the read path adds no register. The bench drives every write on a falling edge and drops or changes the strobe on the next falling edge. It then moves the address to the register of interest and samples one nanosecond later, still half a period before the next rising edge. Burst tests hold the strobe high across consecutive edges and read only after the last one. The bench therefore expects exactly one count step and one fold per edge.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

   // Register word addresses; the order is what software relies on.
   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_FEED   = 2'd1,
      REG_RESULT = 2'd2,
      REG_SPARE  = 2'd3
   } crc_reg_e;

   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_CRC_W  = 16;
   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_CNT_W  = 12;
   localparam int unsigned DEF_CLR_BIT = 15;

endpackage

// File: rtl/crc_fold.sv
// Combinational fold of one data byte into a CRC state. One stage per data
// bit is unrolled; the bit order is picked by a parameter.
module crc_fold #(
   parameter int unsigned W         = 16,
   parameter int unsigned BYTE_W    = 8,
   parameter logic [W-1:0] POLY     = 16'h8408,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic [W-1:0]      crc_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [W-1:0]      crc_out
);

   localparam int unsigned STAGES = BYTE_W + 1;

   if (BYTE_W == 0 || BYTE_W > W) begin : g_bad_width
      $error("crc_fold: BYTE_W must be in 1..W");
   end

   logic [W-1:0] stage [STAGES];

   assign stage[0] = crc_in;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      if (LSB_FIRST) begin : g_lsb
         logic fb;
         assign fb           = stage[i][0] ^ byte_in[i];
         assign stage[i + 1] = (stage[i] >> 1) ^ (fb ? POLY : '0);
      end else begin : g_msb
         logic fb;
         assign fb           = stage[i][W-1] ^ byte_in[BYTE_W-1-i];
         assign stage[i + 1] = (stage[i] << 1) ^ (fb ? POLY : '0);
      end
   end

   assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/crc_state.sv
// CRC state register: clear to the start value, or load the folded value.
module crc_state #(
   parameter int unsigned  W    = 16,
   parameter logic [W-1:0] INIT = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= INIT;
      else if (clr)    q <= INIT;
      else if (load)   q <= nxt;
   end

   p_clear_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == INIT));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load) |=> $stable(q));

endmodule

// File: rtl/byte_counter.sv
// Saturating count of absorbed bytes.
module byte_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("byte_counter: CNT_W must be at least 2");
   end

   logic at_max;
   assign at_max = (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && !at_max)    cnt <= cnt + 1'b1;
   end

   p_clear_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   p_step_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && (cnt != CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));

   p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/crc_byte_engine.sv
// Register-mapped byte-fed CRC accumulator with a saturating byte count.
module crc_byte_engine
   import crc_eng_pkg::*;
#(
   parameter int unsigned         DATA_W    = DEF_DATA_W,
   parameter int unsigned         ADDR_W    = 2,
   parameter int unsigned         CRC_W     = DEF_CRC_W,
   parameter int unsigned         BYTE_W    = DEF_BYTE_W,
   parameter int unsigned         CNT_W     = DEF_CNT_W,
   parameter int unsigned         CLR_BIT   = DEF_CLR_BIT,
   parameter logic [CRC_W-1:0]    POLY      = 16'h8408,
   parameter logic [CRC_W-1:0]    INIT      = 16'hFFFF,
   parameter logic [CRC_W-1:0]    XOROUT    = 16'hFFFF,
   parameter bit                  LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(REG_FEED);
   localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(REG_RESULT);

   if (ADDR_W < 2)         begin : g_bad_addr  $error("ADDR_W too small");        end
   if (CLR_BIT >= DATA_W)  begin : g_bad_clr   $error("CLR_BIT outside word");    end
   if (CNT_W > CLR_BIT)    begin : g_bad_cnt   $error("count overlaps clear bit"); end
   if (CRC_W > DATA_W)     begin : g_bad_crc   $error("CRC wider than word");     end
   if (BYTE_W > DATA_W)    begin : g_bad_byte  $error("byte wider than word");    end

   logic               sel_ctrl, sel_feed, sel_result;
   logic               do_clr, do_feed;
   logic [CRC_W-1:0]   crc_q, crc_nxt;
   logic [CNT_W-1:0]   cnt_q;

   assign sel_ctrl   = (addr == A_CTRL);
   assign sel_feed   = (addr == A_FEED);
   assign sel_result = (addr == A_RESULT);

   assign do_clr  = wr_en && sel_ctrl && wdata[CLR_BIT];
   assign do_feed = wr_en && sel_feed;

   crc_fold #(
      .W         (CRC_W),
      .BYTE_W    (BYTE_W),
      .POLY      (POLY),
      .LSB_FIRST (LSB_FIRST)
   ) u_fold (
      .crc_in  (crc_q),
      .byte_in (wdata[BYTE_W-1:0]),
      .crc_out (crc_nxt)
   );

   crc_state #(
      .W    (CRC_W),
      .INIT (INIT)
   ) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_clr),
      .load  (do_feed),
      .nxt   (crc_nxt),
      .q     (crc_q)
   );

   byte_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_clr),
      .inc   (do_feed),
      .cnt   (cnt_q)
   );

   always_comb begin
      rdata = '0;
      if (sel_ctrl)        rdata[CNT_W-1:0] = cnt_q;
      else if (sel_result) rdata[CRC_W-1:0] = crc_q ^ XOROUT;
   end

   // A feed write must change the count unless it is already saturated.
   p_feed_moves_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (do_feed && (cnt_q != {CNT_W{1'b1}})) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: tb/tb_crc_byte_engine.sv
module tb_crc_byte_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] m_crc;
   logic [11:0] m_cnt;

   always #2 clk = ~clk;

   crc_byte_engine dut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   localparam logic [7:0] VEC [12] = '{
      8'h00, 8'hFF, 8'h01, 8'h80, 8'h5A, 8'hA5,
      8'h7E, 8'h7D, 8'hC0, 8'h33, 8'h10, 8'hEE
   };

   function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
         else             r = r >> 1;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %04h expected %04h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic model_feed(input logic [7:0] b);
      m_crc = ref_fold(m_crc, b);
      if (m_cnt != 12'hFFF) m_cnt = m_cnt + 1'b1;
   endtask

   task automatic check_both(input string tag);
      logic [15:0] v;
      rd(2'd0, v); check({tag, " count"}, v, {4'h0, m_cnt});
      rd(2'd2, v); check({tag, " result"}, v, m_crc ^ 16'hFFFF);
   endtask

   task automatic clear();
      wr(2'd0, 16'h8000);
      m_crc = 16'hFFFF; m_cnt = '0;
   endtask

   initial begin : watchdog
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] v;
      m_crc = 16'hFFFF; m_cnt = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      rd(2'd0, v); check("R1 count after reset", v, 16'h0000);
      rd(2'd2, v); check("R1 result after reset", v, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd2, v); check("R1 result after release", v, 16'h0000);

      // R3, R9: table walk, one write per vector, checked right after
      foreach (VEC[k]) begin
         wr(2'd1, {8'h00, VEC[k]});
         model_feed(VEC[k]);
         check_both("R3 table");
      end

      // R6: check vector after a clear
      clear();
      check_both("R2 after clear");
      wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5);
      wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
      rd(2'd0, v); check("R6 check count", v, 16'h0004);
      rd(2'd2, v); check("R6 check result", v, 16'h51DF);
      m_crc = ref_fold(ref_fold(ref_fold(ref_fold(16'hFFFF, 8'hCC), 8'hF5), 8'hF1), 8'hA7);
      m_cnt = 12'd4;

      // R3: upper byte of feed data ignored
      wr(2'd1, 16'hAB3C);
      model_feed(8'h3C);
      check_both("R3 upper bits ignored");

      // R2: control write without the clear bit has no effect
      wr(2'd0, 16'h7FFF);
      check_both("R2 no clear bit");

      // R8: writes to result and spare addresses ignored
      wr(2'd2, 16'h1234);
      check_both("R8 result write");
      wr(2'd3, 16'hFFFF);
      check_both("R8 spare write");

      // R4: upper control bits read 0 and count steps by one
      wr(2'd1, 16'h0055);
      model_feed(8'h55);
      rd(2'd0, v); check("R4 count step", v, {4'h0, m_cnt});

      // R7: back-to-back feed writes
      clear();
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd1;
      for (int k = 0; k < 5; k++) begin
         wdata = {8'h00, 8'(8'h11 * (k + 1))};
         model_feed(8'(8'h11 * (k + 1)));
         @(negedge clk);
      end
      wr_en = 1'b0;
      check_both("R7 burst");

      // R5: saturation at 0xFFF, CRC still moves
      clear();
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd1;
      for (int k = 0; k < 4097; k++) begin
         wdata = {8'h00, 8'(k * 7)};
         model_feed(8'(k * 7));
         @(negedge clk);
      end
      wr_en = 1'b0;
      rd(2'd0, v); check("R5 saturated count", v, 16'h0FFF);
      rd(2'd2, v); check("R5 result past saturation", v, m_crc ^ 16'hFFFF);
      wr(2'd1, 16'h0099);
      model_feed(8'h99);
      check_both("R5 extra feed");

      // R2: clear from a saturated state
      clear();
      rd(2'd0, v); check("R2 count cleared", v, 16'h0000);
      rd(2'd2, v); check("R2 result cleared", v, 16'h0000);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule